// File: doc/BRIEF.md
# Timer Software Event Generation Unit

This block holds the software event-request register of an advanced PWM timer and the logic those requests drive. Software writes a 1 to a request bit. The bit becomes a one-cycle event pulse and then clears itself. Each pulse sets a sticky status flag. A break request also drops the main output enable. A commutation request moves the preloaded complementary-channel settings into their active copies, but only while the preload-control bit is set.

Status flags are cleared by writing 0 to them. Each flag has an interrupt enable and a DMA enable. The counter, the compare channels and the PWM outputs live elsewhere. They see the update, capture, trigger and break hooks through `evt_pulse`, and they use `moe` and `act_cfg`. All register offsets are byte addresses on one write port and one combinational read port.

Top module: `tmr_evtgen`

## Requirements
- R1: After reset, all status flags, `moe`, the preload-control bit, every event pulse, `irq`, `dma_req` and `act_cfg` are 0.
- R2: A write to offset 0x14 raises `evt_pulse[i]` for each data bit i (8:0) that is 1. The pulse is high for exactly the one cycle after the write. Bits written as 0 and data bits 15:9 give no pulse. Bit order: 0 update, 1..4 capture/compare channels 1..4, 5 commutation, 6 trigger, 7 break, 8 second break.
- R3: A read of offset 0x14 always returns 0.
- R4: Status flags are read at offset 0x10, with flag i at bit i. Event i sets flag i one cycle after its pulse, and the flag stays set.
- R5: A write to 0x10 clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged. An event pulse in the same cycle as a clear keeps its flag set.
- R6: A break or second-break pulse clears `moe` (0x04 bit 0) in the next cycle. This holds even if software writes `moe`=1 in that same cycle.
- R7: Commutation with preload control (0x04 bit 1) at 1 copies the preload register (0x08) to the active copies of channels 0..NCOMP-1. Channel c has its field at bits 5c+4:5c: bit 0 is the channel enable, bit 1 the complementary enable, and bits 4:2 the output mode.
- R8: With preload control at 0, a commutation pulse leaves `act_cfg` unchanged. With preload control at 0, a write to 0x08 reaches `act_cfg` in the next cycle. Channels NCOMP and above have no complementary output, so their active field always follows a write to 0x08 directly.
- R9: `irq` is high when any flag i is set while its interrupt enable (0x0C bit i) is 1.
- R10: `dma_req[i]` pulses for one cycle, in the cycle flag i is set by an event, if its DMA enable (0x0C bit 16+i) is 1. Second break (bit 8) never raises a DMA request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW (8) | Write byte offset |
| wr_data | input | DW (32) | Write data |
| rd_addr | input | AW (8) | Read byte offset |
| rd_data | output | DW (32) | Read data (combinational) |
| evt_pulse | output | 9 | One-cycle event pulses to the timer core |
| stat_flags | output | 9 | Sticky status flags |
| irq | output | 1 | Interrupt request |
| dma_req | output | 9 | Per-flag DMA request pulses |
| moe | output | 1 | Main output enable |
| act_cfg | output | NCH*5 (20) | Active channel output settings |

## Verification
Two pairs of functions can act in the same cycle. The first pair is an event pulse setting a flag and a software write clearing that flag. The second is a break pulse clearing `moe` and a software write setting it. The bench provokes both by issuing the second write in exactly the cycle the event pulse is live. It judges them by the flag staying at 1 and by `moe` staying at 0. A third overlap is a commutation pulse arriving while preload control is 0 or 1, after the preload was changed. It is judged by comparing `act_cfg` against the previous and the new preload values.

// File: rtl/tmr_evt_pkg.sv
package tmr_evt_pkg;
  localparam int NEVT    = 9;
  localparam int EV_UPD  = 0;
  localparam int EV_COM  = 5;
  localparam int EV_TRG  = 6;
  localparam int EV_BRK  = 7;
  localparam int EV_BRK2 = 8;

  localparam logic [7:0] OFF_CTRL = 8'h04;
  localparam logic [7:0] OFF_CFG  = 8'h08;
  localparam logic [7:0] OFF_IEN  = 8'h0C;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_EVT  = 8'h14;

  localparam int DMA_EN_LSB = 16;
  // events allowed to request DMA: all except second break
  localparam logic [NEVT-1:0] DMA_CAPABLE = 9'h0FF;
endpackage

// File: rtl/tmr_evt_req.sv
module tmr_evt_req
  import tmr_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_we,
  input  logic [NEVT-1:0] req_bits,
  output logic [NEVT-1:0] pulse
);
  logic [NEVT-1:0] pulse_d;

  // request bits self-clear: they live exactly one cycle
  always_comb begin
    pulse_d = '0;
    if (req_we) pulse_d = req_bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse <= '0;
    else        pulse <= pulse_d;
  end
endmodule

// File: rtl/tmr_evt_flags.sv
module tmr_evt_flags
  import tmr_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEVT-1:0] set_evt,
  input  logic            clr_we,
  input  logic [NEVT-1:0] clr_keep,
  input  logic [NEVT-1:0] irq_en,
  input  logic [NEVT-1:0] dma_en,
  output logic [NEVT-1:0] flags,
  output logic            irq,
  output logic [NEVT-1:0] dma_req
);
  logic [NEVT-1:0] flags_d;
  logic [NEVT-1:0] dma_d;

  always_comb begin
    flags_d = flags;
    if (clr_we) flags_d = flags & clr_keep;
    flags_d = flags_d | set_evt;             // set beats clear
    dma_d   = set_evt & dma_en & DMA_CAPABLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      dma_req <= '0;
    end else begin
      flags   <= flags_d;
      dma_req <= dma_d;
    end
  end

  assign irq = |(flags & irq_en);
endmodule

// File: rtl/tmr_evt_chcfg.sv
module tmr_evt_chcfg #(
  parameter int NCH   = 4,
  parameter int NCOMP = 3,
  parameter int CW    = 5,
  localparam int CFGW = NCH * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic            ccpc,
  input  logic            com,
  output logic [CFGW-1:0] pre_q,
  output logic [CFGW-1:0] act_q
);
  logic [CFGW-1:0] pre_d;
  logic [CFGW-1:0] act_d;

  always_comb begin
    pre_d = pre_q;
    if (cfg_we) pre_d = cfg_wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g < NCOMP) begin : g_comp
      always_comb begin
        act_d[g*CW +: CW] = act_q[g*CW +: CW];
        if (com && ccpc)
          act_d[g*CW +: CW] = pre_q[g*CW +: CW];
        else if (cfg_we && !ccpc)
          act_d[g*CW +: CW] = cfg_wdata[g*CW +: CW];
      end
    end else begin : g_plain
      always_comb begin
        act_d[g*CW +: CW] = act_q[g*CW +: CW];
        if (cfg_we) act_d[g*CW +: CW] = cfg_wdata[g*CW +: CW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      act_q <= '0;
    end else begin
      pre_q <= pre_d;
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/tmr_evtgen.sv
module tmr_evtgen
  import tmr_evt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NCH   = 4,
  parameter int NCOMP = 3,
  parameter int CW    = 5,
  localparam int CFGW = NCH * CW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic [AW-1:0]   rd_addr,
  output logic [DW-1:0]   rd_data,
  output logic [NEVT-1:0] evt_pulse,
  output logic [NEVT-1:0] stat_flags,
  output logic            irq,
  output logic [NEVT-1:0] dma_req,
  output logic            moe,
  output logic [CFGW-1:0] act_cfg
);
  logic wr_ctrl, wr_cfg, wr_ien, wr_stat, wr_evt;
  logic moe_q, moe_d, ccpc_q, ccpc_d, brk_hit;
  logic [NEVT-1:0] irq_en_q, irq_en_d, dma_en_q, dma_en_d;
  logic [CFGW-1:0] pre_cfg;
  logic unused_wdata;

  assign wr_ctrl = wr_en && (wr_addr == AW'(OFF_CTRL));
  assign wr_cfg  = wr_en && (wr_addr == AW'(OFF_CFG));
  assign wr_ien  = wr_en && (wr_addr == AW'(OFF_IEN));
  assign wr_stat = wr_en && (wr_addr == AW'(OFF_STAT));
  assign wr_evt  = wr_en && (wr_addr == AW'(OFF_EVT));
  assign unused_wdata = ^wr_data;

  tmr_evt_req u_req (
    .clk(clk), .rst_n(rst_n), .req_we(wr_evt),
    .req_bits(wr_data[NEVT-1:0]), .pulse(evt_pulse)
  );

  tmr_evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(evt_pulse),
    .clr_we(wr_stat), .clr_keep(wr_data[NEVT-1:0]),
    .irq_en(irq_en_q), .dma_en(dma_en_q),
    .flags(stat_flags), .irq(irq), .dma_req(dma_req)
  );

  tmr_evt_chcfg #(.NCH(NCH), .NCOMP(NCOMP), .CW(CW)) u_chcfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(wr_cfg),
    .cfg_wdata(wr_data[CFGW-1:0]), .ccpc(ccpc_q),
    .com(evt_pulse[EV_COM]), .pre_q(pre_cfg), .act_q(act_cfg)
  );

  assign brk_hit = evt_pulse[EV_BRK] | evt_pulse[EV_BRK2];

  always_comb begin
    moe_d  = moe_q;
    ccpc_d = ccpc_q;
    if (wr_ctrl) begin
      moe_d  = wr_data[0];
      ccpc_d = wr_data[1];
    end
    if (brk_hit) moe_d = 1'b0;               // break beats software
    irq_en_d = wr_data[NEVT-1:0];
    dma_en_d = wr_data[DMA_EN_LSB +: NEVT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      moe_q  <= 1'b0;
      ccpc_q <= 1'b0;
    end else begin
      moe_q  <= moe_d;
      ccpc_q <= ccpc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q <= '0;
      dma_en_q <= '0;
    end else if (wr_ien) begin
      irq_en_q <= irq_en_d;
      dma_en_q <= dma_en_d;
    end
  end

  assign moe = moe_q;

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(OFF_CTRL))      rd_data = DW'({ccpc_q, moe_q});
    else if (rd_addr == AW'(OFF_CFG))  rd_data = DW'(pre_cfg);
    else if (rd_addr == AW'(OFF_IEN))  rd_data = (DW'(dma_en_q) << DMA_EN_LSB) | DW'(irq_en_q);
    else if (rd_addr == AW'(OFF_STAT)) rd_data = DW'(stat_flags);
  end
endmodule

// File: rtl/tmr_evtgen_chk.sv
module tmr_evtgen_chk
  import tmr_evt_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int NCOMP = 3,
  parameter int CFGW  = 20,
  parameter int CW    = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   wr_addr,
  input logic [AW-1:0]   rd_addr,
  input logic [DW-1:0]   rd_data,
  input logic [NEVT-1:0] evt_pulse,
  input logic [NEVT-1:0] stat_flags,
  input logic [NEVT-1:0] dma_req,
  input logic            moe,
  input logic            ccpc_q,
  input logic [CFGW-1:0] pre_cfg,
  input logic [CFGW-1:0] act_cfg
);
  localparam int COMPW = NCOMP * CW;
  logic wr_evt_c, wr_stat_c;
  assign wr_evt_c  = wr_en && (wr_addr == AW'(OFF_EVT));
  assign wr_stat_c = wr_en && (wr_addr == AW'(OFF_STAT));

  // R2
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0 && !wr_evt_c) |=> (evt_pulse == '0));
  // R3
  evt_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == AW'(OFF_EVT)) |-> (rd_data == '0));
  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((stat_flags & $past(evt_pulse)) == $past(evt_pulse)));
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat_c |=> ((stat_flags & $past(stat_flags)) == $past(stat_flags)));
  // R6
  brk_moe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[EV_BRK] || evt_pulse[EV_BRK2]) |=> !moe);
  // R7
  com_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse[EV_COM] && ccpc_q) |=> (act_cfg[COMPW-1:0] == $past(pre_cfg[COMPW-1:0])));
  // R10
  dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req & ~stat_flags) == '0);
  // R10
  dma_brk2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req[EV_BRK2]);
endmodule

bind tmr_evtgen tmr_evtgen_chk #(.DW(DW), .AW(AW), .NCOMP(NCOMP), .CFGW(CFGW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .rd_addr(rd_addr), .rd_data(rd_data), .evt_pulse(evt_pulse),
  .stat_flags(stat_flags), .dma_req(dma_req), .moe(moe),
  .ccpc_q(ccpc_q), .pre_cfg(pre_cfg), .act_cfg(act_cfg)
);

// File: tb/tmr_evtgen_tb_top.sv
`timescale 1ns/1ps
module tmr_evtgen_tb_top;
  import tmr_evt_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [8:0]  evt_pulse, stat_flags, dma_req;
  logic        irq, moe;
  logic [19:0] act_cfg;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tmr_evtgen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_pulse(evt_pulse), .stat_flags(stat_flags), .irq(irq),
    .dma_req(dma_req), .moe(moe), .act_cfg(act_cfg)
  );

  typedef struct packed {
    logic [15:0] wv;
    logic [8:0]  exp_flags;
    logic        exp_moe;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'h0001, 9'h001, 1'b1},
    '{16'h001E, 9'h01E, 1'b1},
    '{16'h0020, 9'h020, 1'b1},
    '{16'h0040, 9'h040, 1'b1},
    '{16'h0080, 9'h080, 1'b0},
    '{16'h0100, 9'h100, 1'b0},
    '{16'hFE00, 9'h000, 1'b1},
    '{16'hFFFF, 9'h1FF, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = OFF_EVT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 flags", 32'(stat_flags), 32'h0);
    chk("R1 moe", 32'(moe), 32'h0);
    chk("R1 pulse", 32'(evt_pulse), 32'h0);
    chk("R1 act", 32'(act_cfg), 32'h0);
    chk("R1 irq/dma", 32'({irq, dma_req}), 32'h0);
    rd_addr = OFF_CTRL;
    #1 chk("R1 ctrl", rd_data, 32'h0);

    // table walk: R2 pulse, R4 flags, R6 moe
    for (int i = 0; i < 8; i++) begin
      wr(OFF_STAT, 32'h0);
      wr(OFF_CTRL, 32'h1);
      wr(OFF_EVT, 32'(VEC[i].wv));
      chk("R2 pulse", 32'(evt_pulse), 32'(VEC[i].exp_flags));
      step();
      chk("R2 self-clear", 32'(evt_pulse), 32'h0);
      chk("R4 flags", 32'(stat_flags), 32'(VEC[i].exp_flags));
      chk("R6 moe", 32'(moe), 32'(VEC[i].exp_moe));
    end

    // R3 read of request register is zero, even while pulsing
    rd_addr = OFF_EVT;
    wr(OFF_EVT, 32'h0000_01FF);
    chk("R3 evt readback", rd_data, 32'h0);
    step();

    // R5 selective clear and write-1 no effect
    wr(OFF_STAT, 32'h0);
    wr(OFF_EVT, 32'h41);
    step();
    wr(OFF_STAT, 32'hFFFF_FFBF);
    chk("R5 clear bit6", 32'(stat_flags), 32'h001);
    wr(OFF_STAT, 32'hFFFF_FFFF);
    chk("R5 write1 keeps", 32'(stat_flags), 32'h001);
    // R5 event beats clear in same cycle
    wr(OFF_STAT, 32'h0);
    wr(OFF_EVT, 32'h40);
    wr(OFF_STAT, 32'h0);
    chk("R5 event wins", 32'(stat_flags), 32'h040);

    // R6 break beats software moe write
    wr(OFF_CTRL, 32'h1);
    chk("R6 moe set", 32'(moe), 32'h1);
    wr(OFF_EVT, 32'h80);
    wr(OFF_CTRL, 32'h1);
    chk("R6 break wins", 32'(moe), 32'h0);

    // R7 / R8 commutation
    wr(OFF_CTRL, 32'h3);
    wr(OFF_CFG, 32'h000F_FFFF);
    chk("R8 noncomp direct, R7 comp held", 32'(act_cfg), 32'hF8000);
    wr(OFF_EVT, 32'h20);
    step();
    chk("R7 com copies", 32'(act_cfg), 32'hFFFFF);
    wr(OFF_CTRL, 32'h1);
    wr(OFF_CFG, 32'h0001_2345);
    chk("R8 direct when ccpc 0", 32'(act_cfg), 32'h12345);
    wr(OFF_CTRL, 32'h3);
    wr(OFF_CFG, 32'h0);
    chk("R8 comp held, noncomp direct", 32'(act_cfg), 32'h02345);
    wr(OFF_CTRL, 32'h1);
    wr(OFF_EVT, 32'h20);
    step();
    chk("R8 com ignored ccpc 0", 32'(act_cfg), 32'h02345);

    // R10 DMA and R9 irq
    wr(OFF_STAT, 32'h0);
    wr(OFF_IEN, 32'h0140_0000);
    wr(OFF_EVT, 32'h1C0);
    step();
    chk("R10 dma pulse", 32'(dma_req), 32'h040);
    chk("R9 irq disabled", 32'(irq), 32'h0);
    step();
    chk("R10 dma one cycle", 32'(dma_req), 32'h0);
    wr(OFF_IEN, 32'h80);
    chk("R9 irq enabled", 32'(irq), 32'h1);
    wr(OFF_IEN, 32'h20);
    chk("R9 irq flag clear", 32'(irq), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule